// File: doc/BRIEF.md
# HDLC Transmit Frame Sequencer

This block turns a stream of bytes from a transmit FIFO into HDLC frames on a single serial line. Each byte carries a valid flag and an end-of-frame tag. The sequencer opens each frame with a flag and sends the data bytes least significant bit first. After five ones in a row inside data or CRC it inserts a zero. It can add an inverted CRC-CCITT field and closes the frame with a flag. One bit leaves per cycle in which the bit clock enable is high. Between bits the serial output holds its value.

Two conditions are kept apart. A normal end of frame happens when a byte tagged as last is loaded. An underrun happens when the sequencer needs the next byte in mid-frame and the FIFO has none. The response to an underrun is chosen by a 2-bit mode input. A byte becomes the last byte in one of three ways: the FIFO tags it, a one-cycle command marks the next byte loaded, or a per-frame byte counter reaches its limit. A wait-to-send gate lets the current frame finish and then holds back the next frame until the gate is released.

The controller has five states:
- IDLE sends a single mark bit.
- FLAG sends 0x7E.
- DATA sends one byte.
- CRC sends the 16-bit inverted check value.
- ABORT sends 7 or 15 ones.

A new unit is chosen only when the current unit is complete and no stuffed zero is due. The transitions are:
- IDLE goes to FLAG when a byte is available or flag idling is selected; otherwise it stays in IDLE.
- FLAG goes to DATA (frame start) when a byte is available; otherwise it goes to FLAG or IDLE, depending on the idle selection.
- DATA goes to CRC or FLAG after a last byte, depending on the CRC-at-end input. It goes to DATA when another byte is available. It goes to ABORT, FLAG or CRC on an underrun, depending on the mode.
- CRC always goes to FLAG.
- ABORT goes to FLAG when a byte is available or flag idling is selected; otherwise it goes to IDLE.

Top module: `hdlc_tx_seq`

## Requirements
- R1: While reset is low, `txd` is 1 and `fifo_pop`, `eof_pulse` and `urun_pulse` are 0.
- R2: A frame is an opening flag (0x7E), then the data bytes, then a closing flag. Every field is sent least significant bit first, one bit per `bit_en` cycle.
- R3: Inside data and CRC fields, a 0 is inserted after every run of five consecutive 1s. Flags, aborts and idle marks are sent without insertion.
- R4: With `crc_at_end`=1, the last byte is followed by 16 CRC bits. The CRC register starts at 0xFFFF at frame start and is updated over data bits only, with the reflected polynomial 0x8408. It is sent inverted, least significant bit first. With `crc_at_end`=0 no CRC field is sent.
- R5: A byte is tagged as last when any of these holds: `fifo_eof` is high as it is loaded; `set_eof` was pulsed since the previous load, or in the same cycle; or `char_limit` is nonzero and the byte is number `char_limit` of its frame. `eof_pulse` is high for one cycle per tagged byte loaded.
- R6: If a byte is available when a closing flag completes, the next frame starts directly after that flag, so a single flag is shared between the two frames.
- R7: When no byte is available at a flag boundary, the line idles. With `idle_flags`=0 it sends 1s; with `idle_flags`=1 it repeats flags.
- R8: An underrun raises `urun_pulse` for one cycle and never `eof_pulse`. The response follows `urun_mode`:
  - 0: abort of 7 ones.
  - 1: abort of 15 ones.
  - 2: a flag.
  - 3: the inverted CRC followed by a flag.
- R9: With `wts_en`=1, once a tagged last byte has been loaded, no further byte is taken and no new frame starts. This lasts until `wts_en` goes low. The current frame still completes.
- R10: `txd` changes only in cycles after `bit_en` was high.
- R11: `fifo_pop` pulses exactly once for each byte loaded, only when `fifo_valid` was high, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit is sent in each cycle this is high |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_valid | input | 1 | FIFO head byte is present |
| fifo_eof | input | 1 | FIFO head byte is the last of its frame |
| urun_mode | input | 2 | Underrun response select (R8) |
| crc_at_end | input | 1 | Append the CRC after the last byte |
| wts_en | input | 1 | Wait-to-send hold enable |
| set_eof | input | 1 | Command: tag the next byte loaded as last |
| idle_flags | input | 1 | Idle with flags (1) or with ones (0) |
| char_limit | input | 8 | Bytes per frame before automatic tagging; 0 disables |
| txd | output | 1 | Serial data |
| fifo_pop | output | 1 | One-cycle pulse per byte taken |
| eof_pulse | output | 1 | A tagged last byte was loaded |
| urun_pulse | output | 1 | An underrun occurred |

## Verification
Two pairs of functions can meet in the same cycle. First, a last-byte decision can coincide with the sharing of a flag between frames. The bench provokes this by making the counter limit end a frame while the next frame's byte is already present. It then judges the full serial stream, which must show exactly one flag between the frames. Second, a zero insertion can be due at the very slot where a data byte hands over to the CRC field or to the next byte. Runs of ones that cross byte and field boundaries force this case, and the bench compares the stream bit for bit against an expected stream it builds arithmetically. The full sweep of all four underrun modes also checks that the underrun pulse and the end-of-frame pulse never fire together.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLAG  = 3'd1,
        ST_DATA  = 3'd2,
        ST_CRC   = 3'd3,
        ST_ABORT = 3'd4
    } tx_state_e;

    typedef enum logic [1:0] {
        UR_ABORT_SHORT = 2'd0,
        UR_ABORT_LONG  = 2'd1,
        UR_FLAG        = 2'd2,
        UR_CRC_FLAG    = 2'd3
    } urun_mode_e;

    localparam logic [7:0]  FLAG_PATTERN = 8'h7E;
    localparam logic [15:0] CCITT_REFL   = 16'h8408;

endpackage

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit #(
    parameter int CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             preset,
    input  logic             din,
    output logic [CRC_W-1:0] crc_val
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] crc_n;
    logic             fb;

    always_comb begin
        base  = preset ? {CRC_W{1'b1}} : crc_q;
        fb    = base[0] ^ din;
        crc_n = (base >> 1) ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= {CRC_W{1'b1}};
        else if (step_en)
            crc_q <= crc_n;
    end

    assign crc_val = crc_q;
endmodule

// File: rtl/hdlc_tx_tagger.sv
module hdlc_tx_tagger #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_valid,
    input  logic             fifo_eof,
    input  logic             set_eof,
    input  logic             wts_en,
    input  logic [CNT_W-1:0] char_limit,
    input  logic             load_byte,
    input  logic             frame_first,
    output logic             eff_valid,
    output logic             tag_eof,
    output logic             wts_hold
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rem;
    logic             pend_q;
    logic             hold_q;
    logic             cnt_hit;

    always_comb begin
        rem       = frame_first ? char_limit : cnt_q;
        cnt_hit   = (char_limit != '0) && (rem == ONE);
        tag_eof   = fifo_eof | pend_q | set_eof | cnt_hit;
        eff_valid = fifo_valid & ~hold_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (load_byte)
                cnt_q <= rem - ONE;
            if (load_byte)
                pend_q <= 1'b0;
            else if (set_eof)
                pend_q <= 1'b1;
            if (!wts_en)
                hold_q <= 1'b0;
            else if (load_byte && tag_eof)
                hold_q <= 1'b1;
        end
    end

    assign wts_hold = hold_q;
endmodule

// File: rtl/hdlc_tx_core.sv
module hdlc_tx_core
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CRC_W       = 16,
    parameter int STUFF_RUN   = 5,
    parameter int ABORT_SHORT = 7,
    parameter int ABORT_LONG  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              eff_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              tag_eof,
    input  logic [1:0]        urun_mode,
    input  logic              crc_at_end,
    input  logic              idle_flags,
    input  logic [CRC_W-1:0]  crc_val,
    output logic              crc_en,
    output logic              crc_preset,
    output logic              crc_din,
    output logic              load_byte,
    output logic              frame_first,
    output logic              txd,
    output logic              fifo_pop,
    output logic              eof_pulse,
    output logic              urun_pulse
);
    localparam int UNIT_W = CRC_W;
    localparam int LEN_W  = $clog2(UNIT_W + 1);
    localparam int RUN_W  = $clog2(STUFF_RUN + 1);

    tx_state_e         st_q, nst, emit_st;
    logic [UNIT_W-1:0] sreg_q, n_sreg;
    logic [LEN_W-1:0]  bcnt_q, n_len;
    logic [RUN_W-1:0]  run_q, run_base, run_n;
    logic              cur_eof_q;
    logic              take, start, ur;
    logic              stuff_now, slot_load, bit_out, emit_stuffed;
    urun_mode_e        mode;

    assign mode = urun_mode_e'(urun_mode);

    // choice of the next unit when the current one is finished
    always_comb begin
        nst   = st_q;
        take  = 1'b0;
        start = 1'b0;
        ur    = 1'b0;
        unique case (st_q)
            ST_IDLE:  nst = (eff_valid || idle_flags) ? ST_FLAG : ST_IDLE;
            ST_FLAG: begin
                if (eff_valid) begin
                    nst   = ST_DATA;
                    take  = 1'b1;
                    start = 1'b1;
                end else begin
                    nst = idle_flags ? ST_FLAG : ST_IDLE;
                end
            end
            ST_DATA: begin
                if (cur_eof_q) begin
                    nst = crc_at_end ? ST_CRC : ST_FLAG;
                end else if (eff_valid) begin
                    nst  = ST_DATA;
                    take = 1'b1;
                end else begin
                    ur = 1'b1;
                    unique case (mode)
                        UR_ABORT_SHORT, UR_ABORT_LONG: nst = ST_ABORT;
                        UR_FLAG:                       nst = ST_FLAG;
                        UR_CRC_FLAG:                   nst = ST_CRC;
                        default:                       nst = ST_ABORT;
                    endcase
                end
            end
            ST_CRC:   nst = ST_FLAG;
            ST_ABORT: nst = (eff_valid || idle_flags) ? ST_FLAG : ST_IDLE;
            default:  nst = ST_IDLE;
        endcase
    end

    // contents and length of the chosen unit
    always_comb begin
        n_sreg = '1;
        n_len  = LEN_W'(1);
        unique case (nst)
            ST_IDLE: begin
                n_sreg = '1;
                n_len  = LEN_W'(1);
            end
            ST_FLAG: begin
                n_sreg = UNIT_W'(FLAG_PATTERN);
                n_len  = LEN_W'(DATA_W);
            end
            ST_DATA: begin
                n_sreg = UNIT_W'(fifo_data);
                n_len  = LEN_W'(DATA_W);
            end
            ST_CRC: begin
                n_sreg = UNIT_W'(~crc_val);
                n_len  = LEN_W'(CRC_W);
            end
            ST_ABORT: begin
                n_sreg = '1;
                n_len  = (mode == UR_ABORT_LONG) ? LEN_W'(ABORT_LONG) : LEN_W'(ABORT_SHORT);
            end
            default: begin
                n_sreg = '1;
                n_len  = LEN_W'(1);
            end
        endcase
    end

    // bit slot: stuffed zero, first bit of a new unit, or next bit of the current one
    always_comb begin
        stuff_now    = ((st_q == ST_DATA) || (st_q == ST_CRC)) && (run_q == RUN_W'(STUFF_RUN));
        slot_load    = !stuff_now && (bcnt_q == '0);
        emit_st      = slot_load ? nst : st_q;
        bit_out      = stuff_now ? 1'b0 : (slot_load ? n_sreg[0] : sreg_q[0]);
        emit_stuffed = !stuff_now && ((emit_st == ST_DATA) || (emit_st == ST_CRC));
        run_base     = ((st_q == ST_DATA) || (st_q == ST_CRC)) ? run_q : '0;
        run_n        = (emit_stuffed && bit_out) ? run_base + RUN_W'(1) : '0;
        crc_en       = bit_en && !stuff_now && (emit_st == ST_DATA);
        crc_preset   = bit_en && slot_load && start;
        crc_din      = bit_out;
        load_byte    = bit_en && slot_load && take;
        frame_first  = start;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            sreg_q    <= '0;
            bcnt_q    <= '0;
            run_q     <= '0;
            cur_eof_q <= 1'b0;
        end else if (bit_en) begin
            run_q <= run_n;
            if (slot_load) begin
                st_q   <= nst;
                sreg_q <= n_sreg >> 1;
                bcnt_q <= n_len - LEN_W'(1);
                if (take)
                    cur_eof_q <= tag_eof;
            end else if (!stuff_now) begin
                sreg_q <= sreg_q >> 1;
                bcnt_q <= bcnt_q - LEN_W'(1);
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd        <= 1'b1;
            fifo_pop   <= 1'b0;
            eof_pulse  <= 1'b0;
            urun_pulse <= 1'b0;
        end else begin
            fifo_pop   <= load_byte;
            eof_pulse  <= load_byte && tag_eof;
            urun_pulse <= bit_en && slot_load && ur;
            if (bit_en)
                txd <= bit_out;
        end
    end
endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_valid,
    input  logic              fifo_eof,
    input  logic [1:0]        urun_mode,
    input  logic              crc_at_end,
    input  logic              wts_en,
    input  logic              set_eof,
    input  logic              idle_flags,
    input  logic [CNT_W-1:0]  char_limit,
    output logic              txd,
    output logic              fifo_pop,
    output logic              eof_pulse,
    output logic              urun_pulse
);
    localparam int CRC_W = 16;

    logic             eff_valid, tag_eof, wts_hold;
    logic             load_byte, frame_first;
    logic             crc_en, crc_preset, crc_din;
    logic [CRC_W-1:0] crc_val;

    hdlc_tx_tagger #(.CNT_W(CNT_W)) u_tag (
        .clk(clk), .rst_n(rst_n), .fifo_valid(fifo_valid), .fifo_eof(fifo_eof),
        .set_eof(set_eof), .wts_en(wts_en), .char_limit(char_limit),
        .load_byte(load_byte), .frame_first(frame_first),
        .eff_valid(eff_valid), .tag_eof(tag_eof), .wts_hold(wts_hold)
    );

    hdlc_crc_unit #(.CRC_W(CRC_W), .POLY(hdlc_tx_pkg::CCITT_REFL)) u_crc (
        .clk(clk), .rst_n(rst_n), .step_en(crc_en), .preset(crc_preset),
        .din(crc_din), .crc_val(crc_val)
    );

    hdlc_tx_core #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .eff_valid(eff_valid),
        .fifo_data(fifo_data), .tag_eof(tag_eof), .urun_mode(urun_mode),
        .crc_at_end(crc_at_end), .idle_flags(idle_flags), .crc_val(crc_val),
        .crc_en(crc_en), .crc_preset(crc_preset), .crc_din(crc_din),
        .load_byte(load_byte), .frame_first(frame_first), .txd(txd),
        .fifo_pop(fifo_pop), .eof_pulse(eof_pulse), .urun_pulse(urun_pulse)
    );
endmodule

// File: rtl/hdlc_tx_seq_chk.sv
module hdlc_tx_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic fifo_valid,
    input logic txd,
    input logic fifo_pop,
    input logic eof_pulse,
    input logic urun_pulse,
    input logic wts_hold
);
    a_r11_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> $past(fifo_valid));

    a_r11_pop_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    a_r8_eof_urun_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(eof_pulse && urun_pulse));

    a_r5_eof_single: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |=> !eof_pulse);

    a_r10_txd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(txd));

    a_r9_hold_blocks_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (wts_hold && $past(wts_hold)) |-> !fifo_pop);
endmodule

bind hdlc_tx_seq hdlc_tx_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fifo_valid(fifo_valid),
    .txd(txd), .fifo_pop(fifo_pop), .eof_pulse(eof_pulse),
    .urun_pulse(urun_pulse), .wts_hold(wts_hold)
);

// File: tb/hdlc_tx_seq_tb.sv
module hdlc_tx_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_valid = 1'b0;
    logic       fifo_eof = 1'b0;
    logic [1:0] urun_mode = 2'd0;
    logic       crc_at_end = 1'b0;
    logic       wts_en = 1'b0;
    logic       set_eof = 1'b0;
    logic       idle_flags = 1'b0;
    logic [7:0] char_limit = 8'd0;
    logic       txd, fifo_pop, eof_pulse, urun_pulse;

    always #4 clk = ~clk;

    hdlc_tx_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fifo_data(fifo_data),
        .fifo_valid(fifo_valid), .fifo_eof(fifo_eof), .urun_mode(urun_mode),
        .crc_at_end(crc_at_end), .wts_en(wts_en), .set_eof(set_eof),
        .idle_flags(idle_flags), .char_limit(char_limit), .txd(txd),
        .fifo_pop(fifo_pop), .eof_pulse(eof_pulse), .urun_pulse(urun_pulse)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [0:15];
    logic       eofm [0:15];
    int nbytes, idx, pops, eofs, urns, stable_bad, pops_rel, rel_pos, cap_n, ex_n, ones;
    bit cmd_done;
    logic cap [0:2047];
    logic ex [0:1023];
    logic [15:0] crc;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic e_raw(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) begin ex[ex_n] = v[i]; ex_n++; end
        ones = 0;
    endtask
    task automatic e_stuff(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            ex[ex_n] = v[i]; ex_n++;
            ones = v[i] ? ones + 1 : 0;
            if (ones == 5) begin ex[ex_n] = 1'b0; ex_n++; ones = 0; end
        end
    endtask
    task automatic e_flag();  e_raw(16'h007E, 8); endtask
    task automatic e_ones(input int n); e_raw(16'hFFFF, n); endtask
    task automatic e_start(); crc = 16'hFFFF; ones = 0; endtask
    task automatic e_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb  = crc[0] ^ b[i];
            crc = crc >> 1;
            if (fb) crc = crc ^ 16'h8408;
        end
        e_stuff({8'h00, b}, 8);
    endtask
    task automatic e_crc(); e_stuff(~crc, 16); endtask

    task automatic drive_fifo();
        fifo_valid = (idx < nbytes);
        fifo_data  = (idx < nbytes) ? mem[idx] : 8'h00;
        fifo_eof   = (idx < nbytes) ? eofm[idx] : 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) begin mem[i] = 8'h00; eofm[i] = 1'b0; end
    endtask

    task automatic do_reset(input bit chk_it);
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; set_eof = 1'b0;
        idx = 0; pops = 0; eofs = 0; urns = 0; stable_bad = 0; cap_n = 0;
        pops_rel = -1; rel_pos = 0; cmd_done = 1'b0;
        drive_fifo();
        repeat (3) @(negedge clk);
        if (chk_it)
            chk(txd === 1'b1 && fifo_pop === 1'b0 && eof_pulse === 1'b0 && urun_pulse === 1'b0,
                "R1 reset outputs", {28'd0, txd, fifo_pop, eof_pulse, urun_pulse}, 8);
        rst_n = 1'b1;
    endtask

    task automatic run(input int ncyc, input int eof_cmd_at, input int release_at, input bit half);
        logic be_prev;
        bit_en = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            @(posedge clk);
            be_prev = bit_en;
            @(negedge clk);
            if (be_prev) begin cap[cap_n] = txd; cap_n++; end
            else if (cap_n > 0 && txd !== cap[cap_n-1]) stable_bad++;
            if (fifo_pop) begin pops++; idx++; end
            if (eof_pulse) eofs++;
            if (urun_pulse) urns++;
            set_eof = 1'b0;
            if (eof_cmd_at >= 0 && !cmd_done && pops == eof_cmd_at) begin
                set_eof = 1'b1; cmd_done = 1'b1;
            end
            if (c == release_at) begin pops_rel = pops; rel_pos = cap_n; wts_en = 1'b0; end
            drive_fifo();
            bit_en = half ? ~bit_en : 1'b1;
        end
        bit_en = 1'b0; set_eof = 1'b0;
    endtask

    task automatic compare(input int from, input string tag);
        int s, bad;
        s = from;
        while (s < cap_n && cap[s] !== 1'b0) s++;
        bad = -1;
        for (int i = 0; i < ex_n; i++) begin
            if (s + i >= cap_n || cap[s+i] !== ex[i]) begin bad = i; break; end
        end
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, {tag, " bit at stream index (actual,expected shown as index and bit)"},
                 (s + bad < cap_n) ? int'(cap[s+bad]) : -1, int'(ex[bad]));
    endtask

    initial begin
        #1600000;
        errors++; checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R2 R4 R5 R11: plain frame with CRC
        clear_mem(); nbytes = 3;
        mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'h56; eofm[2] = 1'b1;
        crc_at_end = 1'b1; idle_flags = 1'b0; urun_mode = 2'd0; char_limit = 8'd0; wts_en = 1'b0;
        do_reset(1'b1); run(160, -1, -1, 1'b0);
        ex_n = 0; e_flag(); e_start(); e_byte(8'h12); e_byte(8'h34); e_byte(8'h56); e_crc(); e_flag(); e_ones(16);
        compare(0, "R2 R4 basic frame");
        chk(pops == 3, "R11 pop count", pops, 3);
        chk(eofs == 1, "R5 eof pulse count", eofs, 1);
        chk(urns == 0, "R8 no underrun on clean frame", urns, 0);

        // R3: runs of ones across bytes and into the CRC
        clear_mem(); nbytes = 4;
        mem[0] = 8'hFF; mem[1] = 8'h3E; mem[2] = 8'hF8; mem[3] = 8'hFF; eofm[3] = 1'b1;
        do_reset(1'b0); run(200, -1, -1, 1'b0);
        ex_n = 0; e_flag(); e_start(); e_byte(8'hFF); e_byte(8'h3E); e_byte(8'hF8); e_byte(8'hFF); e_crc(); e_flag(); e_ones(16);
        compare(0, "R3 zero insertion");

        // R4: no CRC field
        clear_mem(); nbytes = 2; mem[0] = 8'hA5; mem[1] = 8'h0F; eofm[1] = 1'b1; crc_at_end = 1'b0;
        do_reset(1'b0); run(120, -1, -1, 1'b0);
        ex_n = 0; e_flag(); e_start(); e_byte(8'hA5); e_byte(8'h0F); e_flag(); e_ones(16);
        compare(0, "R4 frame without CRC");

        // R5 R6: counter limit, second frame shares the closing flag
        clear_mem(); nbytes = 6; crc_at_end = 1'b1; char_limit = 8'd3;
        for (int i = 0; i < 6; i++) mem[i] = 8'(8'h21 + 8'(i * 17));
        do_reset(1'b0); run(260, -1, -1, 1'b0);
        ex_n = 0; e_flag();
        e_start(); for (int i = 0; i < 3; i++) e_byte(mem[i]); e_crc(); e_flag();
        e_start(); for (int i = 3; i < 6; i++) e_byte(mem[i]); e_crc(); e_flag(); e_ones(16);
        compare(0, "R6 R5 shared flag with counter tagging");
        chk(eofs == 2, "R5 counter eof pulses", eofs, 2);
        chk(pops == 6, "R11 pop count two frames", pops, 6);
        char_limit = 8'd0;

        // R5: set-EOF command tags the third byte
        clear_mem(); nbytes = 3; mem[0] = 8'h5A; mem[1] = 8'hC3; mem[2] = 8'h99;
        do_reset(1'b0); run(160, 2, -1, 1'b0);
        ex_n = 0; e_flag(); e_start(); e_byte(8'h5A); e_byte(8'hC3); e_byte(8'h99); e_crc(); e_flag(); e_ones(16);
        compare(0, "R5 command-tagged end");
        chk(eofs == 1 && urns == 0, "R5 command eof without underrun", eofs * 10 + urns, 10);

        // R8: sweep of underrun responses, flag idling
        for (int m = 0; m < 4; m++) begin
            clear_mem(); nbytes = 2; mem[0] = 8'h81; mem[1] = 8'h42;
            urun_mode = 2'(m); idle_flags = 1'b1; crc_at_end = 1'b0;
            do_reset(1'b0); run(160, -1, -1, 1'b0);
            ex_n = 0; e_flag(); e_start(); e_byte(8'h81); e_byte(8'h42);
            case (m)
                0: e_ones(7);
                1: e_ones(15);
                2: e_flag();
                default: begin e_crc(); e_flag(); end
            endcase
            e_flag(); e_flag();
            compare(0, "R8 underrun response stream");
            chk(urns == 1 && eofs == 0, "R8 underrun pulse only", urns * 10 + eofs, 10);
        end
        urun_mode = 2'd0;

        // R7: idle with repeated flags
        clear_mem(); nbytes = 1; mem[0] = 8'h3C; eofm[0] = 1'b1; idle_flags = 1'b1; crc_at_end = 1'b0;
        do_reset(1'b0); run(100, -1, -1, 1'b0);
        ex_n = 0; e_flag(); e_start(); e_byte(8'h3C); e_flag(); e_flag(); e_flag(); e_flag();
        compare(0, "R7 flag idling");
        idle_flags = 1'b0;

        // R9: wait-to-send hold between two frames
        clear_mem(); nbytes = 4; crc_at_end = 1'b1;
        mem[0] = 8'h11; mem[1] = 8'h22; eofm[1] = 1'b1; mem[2] = 8'h33; mem[3] = 8'h44; eofm[3] = 1'b1;
        wts_en = 1'b1;
        do_reset(1'b0); run(360, -1, 150, 1'b0);
        ex_n = 0; e_flag(); e_start(); e_byte(8'h11); e_byte(8'h22); e_crc(); e_flag(); e_ones(40);
        compare(0, "R9 first frame then hold");
        chk(pops_rel == 2, "R9 no byte taken while held", pops_rel, 2);
        ex_n = 0; e_flag(); e_start(); e_byte(8'h33); e_byte(8'h44); e_crc(); e_flag(); e_ones(16);
        compare(rel_pos, "R9 second frame after release");
        chk(pops == 4, "R11 pops after release", pops, 4);

        // R10: half-rate bit enable
        clear_mem(); nbytes = 3; wts_en = 1'b0;
        mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'h56; eofm[2] = 1'b1;
        do_reset(1'b0); run(320, -1, -1, 1'b1);
        ex_n = 0; e_flag(); e_start(); e_byte(8'h12); e_byte(8'h34); e_byte(8'h56); e_crc(); e_flag(); e_ones(16);
        compare(0, "R10 half-rate stream");
        chk(stable_bad == 0, "R10 txd steady without bit_en", stable_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule